// File: doc/BRIEF.md
# Circular Reorder Buffer with Range Voiding

This block is a circular in-order reorder buffer for an out-of-order core. Instructions enter at the tail and receive the slot index they occupy. Execution units mark slots as finished by index. The buffer releases the oldest slot at the head once that slot is finished. Entries keep their positions from allocation to release and are never moved.

A mispredicted branch does not pull the tail back. The front end instead names an inclusive circular span of slot indices, which may wrap past the last slot, and every occupied slot in that span is flagged as voided. A voided slot reaches the head in its normal turn and is released without committing, one per cycle, and it does not have to be finished first. Slots allocated after the span, such as a newly fetched handler stream, stay in place and commit normally. An exception flush drops everything, handler slots included.

Top module: `rob_void_ring`

## Requirements
- R1: After reset the buffer is empty: `occupancy` is 0, `alloc_ready` is 1, `ret_valid` is 0 and `alloc_idx` is 0.
- R2: Each accepted allocation takes the slot shown on `alloc_idx`. Slot indices rise by one per allocation modulo 32, and the stored tag appears on `ret_tag` when that slot is released.
- R3: With 32 slots occupied, `alloc_ready` is 0 and an allocation request has no effect on `occupancy` or `alloc_idx`. This holds even when some occupied slots are voided.
- R4: The head slot is released with `ret_commit`=1 only after a completion for its index. An unfinished, non-void head keeps `ret_valid` at 0.
- R5: A void request with `void_first`==`void_last` voids exactly that one slot. A voided slot is released with `ret_commit`=0 whether or not it has finished.
- R6: If `void_first` > `void_last`, the span wraps. It covers `void_first`..31 and 0..`void_last`.
- R7: Slots outside the span, including slots allocated after the void request, are released in order with `ret_commit`=1 once finished.
- R8: A cycle with `flush`=1 reports no release and accepts no allocation. From the next cycle the buffer is empty, and the next allocation uses slot 0.
- R9: At most one slot is released per cycle, in slot order. `occupancy` equals accepted allocations minus releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_tag | input | 8 | Payload stored with the new slot |
| alloc_ready | output | 1 | A free slot exists |
| alloc_idx | output | 5 | Slot the next allocation takes |
| cmpl_valid | input | 1 | Completion strobe |
| cmpl_idx | input | 5 | Slot that finished |
| void_valid | input | 1 | Void request |
| void_first | input | 5 | First slot of the inclusive span |
| void_last | input | 5 | Last slot of the inclusive span |
| flush | input | 1 | Drop all slots |
| ret_valid | output | 1 | Head slot is released this cycle |
| ret_commit | output | 1 | 1: commit, 0: discard |
| ret_idx | output | 5 | Index of the head slot |
| ret_tag | output | 8 | Tag of the head slot |
| occupancy | output | 6 | Number of occupied slots |

## Verification
The checks assume a well-behaved environment. Completions name only occupied slots that are not being allocated in the same cycle. A void span never reaches a slot allocated in that same cycle. The bench issues completions only for slots it allocated earlier, and it places void spans over occupied slots while holding allocation idle. Fill-to-full, wrapped spans, single-slot spans, late handler allocations and flush with a pending allocation are driven as directed sequences.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int ROB_DEPTH = 32;
    localparam int ROB_TAG_W = 8;

    typedef struct packed {
        logic                 valid;
        logic                 done;
        logic                 voided;
        logic [ROB_TAG_W-1:0] tag;
    } rob_entry_t;
endpackage

// File: rtl/rob_range_mask.sv
module rob_range_mask #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             en,
    input  logic [AW-1:0]    first,
    input  logic [AW-1:0]    last,
    output logic [DEPTH-1:0] mask
);
    logic wrap;
    assign wrap = first > last;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic ge_first, le_last;
        assign ge_first = AW'(i) >= first;
        assign le_last  = AW'(i) <= last;
        assign mask[i]  = en && (wrap ? (ge_first || le_last) : (ge_first && le_last));
    end

    // Single-slot span selects exactly one slot
    always_comb begin
        if (en && first == last)
            assert_single_slot_R5: assert ($countones(mask) == 1);
    end
endmodule

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          adv_tail,
    input  logic          adv_head,
    output logic [AW-1:0] head_idx,
    output logic [AW-1:0] tail_idx,
    output logic [AW:0]   count,
    output logic          full
);
    typedef struct packed {
        logic [AW:0] head;
        logic [AW:0] tail;
    } ptr_t;

    ptr_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.head = '0;
            s_d.tail = '0;
        end else begin
            if (adv_tail) s_d.tail = s_q.tail + 1'b1;
            if (adv_head) s_d.head = s_q.head + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head_idx = s_q.head[AW-1:0];
    assign tail_idx = s_q.tail[AW-1:0];
    assign count    = s_q.tail - s_q.head;
    assign full     = count == (AW+1)'(DEPTH);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH));

    assert_step_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (count == $past(count) || count == $past(count) + 1'b1
                    || count + 1'b1 == $past(count)));
endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array
    import rob_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_idx,
    input  logic [ROB_TAG_W-1:0] wr_tag,
    input  logic                 cmpl_en,
    input  logic [AW-1:0]        cmpl_idx,
    input  logic [DEPTH-1:0]     void_mask,
    input  logic                 clr_en,
    input  logic [AW-1:0]        clr_idx,
    input  logic [AW-1:0]        head_idx,
    output rob_entry_t           head_entry
);
    rob_entry_t [DEPTH-1:0] ent_q, ent_d;

    always_comb begin
        ent_d = ent_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (void_mask[i] && ent_q[i].valid) ent_d[i].voided = 1'b1;
        end
        if (cmpl_en && ent_q[cmpl_idx].valid) ent_d[cmpl_idx].done = 1'b1;
        if (clr_en) ent_d[clr_idx].valid = 1'b0;
        if (wr_en) begin
            ent_d[wr_idx].valid  = 1'b1;
            ent_d[wr_idx].done   = 1'b0;
            ent_d[wr_idx].voided = 1'b0;
            ent_d[wr_idx].tag    = wr_tag;
        end
        if (flush) begin
            for (int i = 0; i < DEPTH; i++) ent_d[i].valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign head_entry = ent_q[head_idx];

    // A slot is never written while still occupied
    assert_write_free_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !ent_q[wr_idx].valid);
endmodule

// File: rtl/rob_void_ring.sv
module rob_void_ring
    import rob_pkg::*;
#(
    parameter int DEPTH = ROB_DEPTH,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_valid,
    input  logic [ROB_TAG_W-1:0] alloc_tag,
    output logic                 alloc_ready,
    output logic [AW-1:0]        alloc_idx,
    input  logic                 cmpl_valid,
    input  logic [AW-1:0]        cmpl_idx,
    input  logic                 void_valid,
    input  logic [AW-1:0]        void_first,
    input  logic [AW-1:0]        void_last,
    input  logic                 flush,
    output logic                 ret_valid,
    output logic                 ret_commit,
    output logic [AW-1:0]        ret_idx,
    output logic [ROB_TAG_W-1:0] ret_tag,
    output logic [AW:0]          occupancy
);
    logic             full, alloc_fire;
    logic [AW-1:0]    head_idx, tail_idx;
    logic [DEPTH-1:0] span;
    rob_entry_t       head_entry;

    assign alloc_fire = alloc_valid && !full && !flush;

    rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .adv_tail(alloc_fire), .adv_head(ret_valid),
        .head_idx(head_idx), .tail_idx(tail_idx),
        .count(occupancy), .full(full)
    );

    rob_range_mask #(.DEPTH(DEPTH)) u_span (
        .en(void_valid && !flush), .first(void_first), .last(void_last), .mask(span)
    );

    rob_entry_array #(.DEPTH(DEPTH)) u_ents (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(alloc_fire), .wr_idx(tail_idx), .wr_tag(alloc_tag),
        .cmpl_en(cmpl_valid && !flush), .cmpl_idx(cmpl_idx),
        .void_mask(span),
        .clr_en(ret_valid), .clr_idx(head_idx),
        .head_idx(head_idx), .head_entry(head_entry)
    );

    assign alloc_ready = !full;
    assign alloc_idx   = tail_idx;
    assign ret_valid   = !flush && head_entry.valid && (head_entry.voided || head_entry.done);
    assign ret_commit  = !head_entry.voided;
    assign ret_idx     = head_idx;
    assign ret_tag     = head_entry.tag;

    assert_commit_needs_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_commit) |-> head_entry.done);

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occupancy == '0 && !ret_valid && alloc_idx == '0));

    assert_alloc_in_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && !flush) |=> alloc_idx == $past(alloc_idx) + 1'b1);
endmodule

// File: tb/rob_void_ring_tb.sv
module rob_void_ring_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_valid = 1'b0;
    logic [7:0] alloc_tag = '0;
    logic       alloc_ready;
    logic [4:0] alloc_idx;
    logic       cmpl_valid = 1'b0;
    logic [4:0] cmpl_idx = '0;
    logic       void_valid = 1'b0;
    logic [4:0] void_first = '0, void_last = '0;
    logic       flush = 1'b0;
    logic       ret_valid, ret_commit;
    logic [4:0] ret_idx;
    logic [7:0] ret_tag;
    logic [5:0] occupancy;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rob_void_ring u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx),
        .void_valid(void_valid), .void_first(void_first), .void_last(void_last),
        .flush(flush),
        .ret_valid(ret_valid), .ret_commit(ret_commit), .ret_idx(ret_idx),
        .ret_tag(ret_tag), .occupancy(occupancy)
    );

    // {alloc, cv, cidx, vv, vfirst, vlast, flush, exp_rv, exp_rc, exp_ridx, exp_cnt}
    localparam int NV = 10;
    localparam logic [31:0] VEC [NV] = '{
        {1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 6'd0},
        {1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 6'd1},
        {1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 6'd2},
        {1'b0, 1'b1, 5'd1, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 6'd3},
        {1'b0, 1'b1, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 6'd3},
        {1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b1, 1'b1, 5'd0, 6'd3},
        {1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b1, 1'b1, 5'd1, 6'd2},
        {1'b0, 1'b0, 5'd0, 1'b1, 5'd2, 5'd2, 1'b0, 1'b0, 1'b0, 5'd0, 6'd1},
        {1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b1, 1'b0, 5'd2, 6'd1},
        {1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 6'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive inputs at the falling edge, then let outputs settle
    task automatic drive(input bit a, input logic [7:0] tg, input bit cv, input int ci,
                         input bit vv, input int vf, input int vl, input bit fl);
        @(negedge clk);
        alloc_valid = a; alloc_tag = tg;
        cmpl_valid = cv; cmpl_idx = 5'(ci);
        void_valid = vv; void_first = 5'(vf); void_last = 5'(vl);
        flush = fl;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 8'h00, 1'b0, 0, 1'b0, 0, 0, 1'b0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 occupancy", int'(occupancy), 0);
        chk("R1 alloc_ready", int'(alloc_ready), 1);
        chk("R1 ret_valid", int'(ret_valid), 0);
        chk("R1 alloc_idx", int'(alloc_idx), 0);

        // Table: basic in-order commit and a single-slot void
        for (int v = 0; v < NV; v++) begin
            logic [31:0] w;
            w = VEC[v];
            drive(w[31], 8'(8'h50 + v), w[30], int'(w[29:25]), w[24],
                  int'(w[23:19]), int'(w[18:14]), w[13]);
            chk("R9 occupancy", int'(occupancy), int'(w[5:0]));
            chk("R4 ret_valid", int'(ret_valid), int'(w[12]));
            if (w[12]) begin
                chk("R5 ret_commit", int'(ret_commit), int'(w[11]));
                chk("R9 ret_idx", int'(ret_idx), int'(w[10:6]));
            end
        end

        // Fill to full from slot 3
        for (int i = 0; i < 32; i++) begin
            drive(1'b1, 8'(i * 3 + 1), 1'b0, 0, 1'b0, 0, 0, 1'b0);
            chk("R2 alloc_idx", int'(alloc_idx), (3 + i) % 32);
        end
        drive(1'b1, 8'hEE, 1'b0, 0, 1'b0, 0, 0, 1'b0);
        chk("R3 alloc_ready full", int'(alloc_ready), 0);
        chk("R3 occupancy full", int'(occupancy), 32);
        idle();
        chk("R3 occupancy after refused alloc", int'(occupancy), 32);
        chk("R3 alloc_idx after refused alloc", int'(alloc_idx), 3);
        for (int s = 5; s <= 29; s++) begin
            drive(1'b0, 8'h00, 1'b1, s, 1'b0, 0, 0, 1'b0);
            chk("R4 unfinished head holds", int'(ret_valid), 0);
        end
        drive(1'b0, 8'h00, 1'b0, 0, 1'b1, 30, 4, 1'b0);
        idle();
        chk("R3 alloc_ready with voided slots", int'(alloc_ready), 0);
        for (int k = 0; k < 32; k++) begin
            int idx;
            idx = (3 + k) % 32;
            if (k > 0) idle();
            chk("R9 drain ret_valid", int'(ret_valid), 1);
            chk("R9 drain ret_idx", int'(ret_idx), idx);
            chk("R6 wrapped span commit flag", int'(ret_commit),
                (idx >= 5 && idx <= 29) ? 1 : 0);
            chk("R2 ret_tag", int'(ret_tag), (k * 3 + 1) % 256);
            chk("R9 drain occupancy", int'(occupancy), 32 - k);
        end
        idle();
        chk("R9 empty after drain", int'(occupancy), 0);

        // Single-slot void, then a later handler stream
        for (int i = 0; i < 3; i++) drive(1'b1, 8'(8'h70 + i), 1'b0, 0, 1'b0, 0, 0, 1'b0);
        drive(1'b0, 8'h00, 1'b0, 0, 1'b1, 4, 4, 1'b0);
        for (int i = 3; i < 5; i++) drive(1'b1, 8'(8'h70 + i), 1'b0, 0, 1'b0, 0, 0, 1'b0);
        drive(1'b0, 8'h00, 1'b1, 7, 1'b0, 0, 0, 1'b0);
        drive(1'b0, 8'h00, 1'b1, 6, 1'b0, 0, 0, 1'b0);
        drive(1'b0, 8'h00, 1'b1, 5, 1'b0, 0, 0, 1'b0);
        drive(1'b0, 8'h00, 1'b1, 3, 1'b0, 0, 0, 1'b0);
        chk("R4 head not yet finished", int'(ret_valid), 0);
        for (int k = 0; k < 5; k++) begin
            idle();
            chk("R7 ret_valid", int'(ret_valid), 1);
            chk("R7 ret_idx", int'(ret_idx), 3 + k);
            chk(k == 1 ? "R5 single slot discarded" : "R7 handler slot commits",
                int'(ret_commit), k == 1 ? 0 : 1);
            chk("R7 ret_tag", int'(ret_tag), 8'h70 + k);
        end
        idle();
        chk("R7 empty", int'(occupancy), 0);

        // Flush with a pending allocation
        for (int i = 0; i < 4; i++) drive(1'b1, 8'(8'h90 + i), 1'b0, 0, 1'b0, 0, 0, 1'b0);
        drive(1'b1, 8'hAA, 1'b0, 0, 1'b0, 0, 0, 1'b1);
        chk("R8 no release in flush cycle", int'(ret_valid), 0);
        idle();
        chk("R8 occupancy", int'(occupancy), 0);
        chk("R8 ret_valid", int'(ret_valid), 0);
        chk("R8 alloc_ready", int'(alloc_ready), 1);
        chk("R8 alloc_idx", int'(alloc_idx), 0);
        drive(1'b1, 8'h5C, 1'b0, 0, 1'b0, 0, 0, 1'b0);
        drive(1'b0, 8'h00, 1'b1, 0, 1'b0, 0, 0, 1'b0);
        idle();
        chk("R8 post-flush commit", int'(ret_valid), 1);
        chk("R8 post-flush tag", int'(ret_tag), 8'h5C);
        idle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule